// File: doc/BRIEF.md
# OTP Protection Register Controller

This block holds a 128-bit one-time-programmable protection register behind a flash-style command interface. One 64-bit half carries a fixed identity value, preloaded at reset from a parameter, which can never change. The other 64-bit half starts erased (all ones) and can be programmed by software. A separate lock word decides whether each half may still be programmed. Bus writes carry command codes, or an address and data when a program sequence is open. Bus reads return all ones in array mode, register contents in identification mode, and the status byte otherwise. A `byte_mode` input selects 16-bit or 8-bit bus addressing.

Programming takes two writes. The first write is the setup code 0xC0. The second write supplies the address and data together. The stored word becomes the AND of its old value and the new data, so a bit can only go from 1 to 0. The register space occupies word offsets 0x80 to 0x88 from the base:
- 0x80 is the lock word. Bit 0 cleared means the fixed half is locked, and it is cleared at reset. Bit 1 cleared means the user half is locked.
- 0x81 to 0x84 hold the fixed half, least significant word first.
- 0x85 to 0x88 hold the user half.

The controller has five states:
- `ST_ARRAY` is the reset state and serves array reads.
- `ST_IDENT` serves identification reads.
- `ST_STATUS` shows the status byte.
- `ST_PSETUP` waits for the program data.
- `ST_BUSY` models the program time.

Its transitions are:
- From `ST_ARRAY`, `ST_IDENT` or `ST_STATUS`, command 0xFF goes to `ST_ARRAY`, 0x90 goes to `ST_IDENT`, and 0xC0 goes to `ST_PSETUP`. Command 0x50 clears the error bits and keeps the current state.
- From `ST_PSETUP`, any write goes to `ST_BUSY`.
- From `ST_BUSY`, the controller goes to `ST_STATUS` once `BUSY_CYCLES` cycles have passed.

Top module: `otp_prot_ctrl`

## Requirements
- R1: After reset the block is in array mode, where reads return 0xFFFF, and the status byte reads 0x80 (bit 7 ready, no error bits).
- R2: Writing command 0x90 enters identification mode. Reads at word addresses 0x81..0x84 return the fixed value, least significant word first. Reads at 0x85..0x88 return the user words, which are 0xFFFF when erased. Reads at 0x80 return the lock word, which is 0xFFFE after reset. Reads outside the space return 0.
- R3: Writing command 0xFF returns the block to array mode, where reads return 0xFFFF.
- R4: Command 0xC0 followed by one write of address and data programs that word with the AND of its old and new values. A later program with ones leaves cleared bits at 0.
- R5: In byte mode the byte address is twice the word address plus a lane bit (lane 0 is bits 7:0). A program changes only that byte, using wdata[7:0]. A read returns the byte in rdata[7:0], with rdata[15:8] at 0.
- R6: A program at an address outside 0x80..0x88 changes no stored word and sets status bit 4 only, so status reads 0x90 once ready.
- R7: A program into a locked half changes nothing and sets status bits 4 and 1, so status reads 0x92 once ready. The fixed half is always locked.
- R8: Clearing bit 1 of the lock word at 0x80 locks the user half against further programming.
- R9: After the program write, reads return the status byte, and bit 7 reads 0 for exactly `BUSY_CYCLES` cycles before it returns to 1. Writes during that time are ignored.
- R10: Command 0x50 clears status bits 4 and 1 and leaves the read mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; reloads the fixed half and the erased state |
| byte_mode | input | 1 | 1 selects 8-bit byte addressing, 0 selects 16-bit word addressing |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| addr | input | ADDR_W | Bus address, a word or byte address depending on `byte_mode` |
| wdata | input | 16 | Write data: a command code in bits 7:0, or program data |
| rdata | output | 16 | Read data for the current mode and address |

## Verification
On every cycle, the assertions check the following:
- No stored bit rises from 0 to 1.
- The fixed half never changes.
- `ST_BUSY` is entered only from a write in `ST_PSETUP`, and is left only towards `ST_STATUS`.
- An error bit rises only on a failed program.
- The lock error never appears without the program error.
- A clear-status command leaves both error bits at 0.

Only the bench scenarios can show the rest:
- The values actually read back in each mode.
- The byte-lane mapping.
- That locking through the lock word stops a later program.
- The exact length of the busy window.
- That a command written during busy is dropped.

// File: rtl/otp_prot_pkg.sv
package otp_prot_pkg;

    typedef enum logic [2:0] {
        ST_ARRAY  = 3'd0,
        ST_IDENT  = 3'd1,
        ST_STATUS = 3'd2,
        ST_PSETUP = 3'd3,
        ST_BUSY   = 3'd4
    } otp_state_e;

    typedef enum logic [1:0] {
        SEG_LOCK = 2'd0,
        SEG_FACT = 2'd1,
        SEG_USER = 2'd2,
        SEG_NONE = 2'd3
    } otp_seg_e;

    localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
    localparam logic [7:0] CMD_READ_ID    = 8'h90;
    localparam logic [7:0] CMD_PROG_SETUP = 8'hC0;
    localparam logic [7:0] CMD_CLR_STATUS = 8'h50;

    localparam int PR_WORDS    = 9;
    localparam int SLOT_LOCK   = 0;
    localparam int SLOT_FACT_0 = 1;
    localparam int SLOT_FACT_N = 4;
    localparam int SLOT_USER_0 = 5;
    localparam int SLOT_W      = 4;

    localparam logic [15:0] LOCK_PRELOAD = 16'hFFFE;

endpackage

// File: rtl/otp_addr_dec.sv
module otp_addr_dec
    import otp_prot_pkg::*;
#(
    parameter int              ADDR_W  = 9,
    parameter logic [ADDR_W-1:0] PR_BASE = 'h80
) (
    input  logic              byte_mode,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              lane,
    output logic [SLOT_W-1:0] slot,
    output otp_seg_e          seg
);

    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] off;

    always_comb begin
        waddr = byte_mode ? (addr >> 1) : addr;
        lane  = byte_mode & addr[0];
        off   = waddr - PR_BASE;
        hit   = (waddr >= PR_BASE) && (off < ADDR_W'(PR_WORDS));
        slot  = hit ? off[SLOT_W-1:0] : '0;
        if (!hit)
            seg = SEG_NONE;
        else if (int'(slot) == SLOT_LOCK)
            seg = SEG_LOCK;
        else if (int'(slot) <= SLOT_FACT_N)
            seg = SEG_FACT;
        else
            seg = SEG_USER;
    end

endmodule

// File: rtl/otp_store.sv
module otp_store
    import otp_prot_pkg::*;
#(
    parameter logic [63:0] FACTORY_ID = 64'h0123_4567_89AB_CDEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic [SLOT_W-1:0] slot,
    input  logic              byte_mode,
    input  logic              lane,
    input  logic [15:0]       wdata,
    output logic [15:0]       words [PR_WORDS],
    output logic              fact_locked,
    output logic              user_locked
);

    function automatic logic [15:0] preload(input int idx);
        if (idx == SLOT_LOCK)
            return LOCK_PRELOAD;
        else if (idx <= SLOT_FACT_N)
            return FACTORY_ID[16*(idx-SLOT_FACT_0) +: 16];
        else
            return 16'hFFFF;
    endfunction

    logic [15:0] mask;

    always_comb begin
        if (!byte_mode)
            mask = wdata;
        else if (lane)
            mask = {wdata[7:0], 8'hFF};
        else
            mask = {8'hFF, wdata[7:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PR_WORDS; i++)
                words[i] <= preload(i);
        end else if (prog_en) begin
            words[slot] <= words[slot] & mask;
        end
    end

    assign fact_locked = ~words[SLOT_LOCK][0];
    assign user_locked = ~words[SLOT_LOCK][1];

    for (genvar g = 0; g < PR_WORDS; g++) begin : g_word_chk
        assert_word_no_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ((~$past(words[g]) & words[g]) == 16'h0000));
        if (g >= SLOT_FACT_0 && g <= SLOT_FACT_N) begin : g_fact
            assert_factory_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
                $stable(words[g]));
        end
    end

endmodule

// File: rtl/otp_cmd_fsm.sv
module otp_cmd_fsm
    import otp_prot_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] cmd,
    input  logic       hit,
    input  otp_seg_e   seg,
    input  logic       fact_locked,
    input  logic       user_locked,
    output otp_state_e state,
    output logic [7:0] status,
    output logic       prog_en
);

    localparam int CNT_W = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

    otp_state_e       state_nxt;
    logic [CNT_W-1:0] cnt;
    logic             cnt_load;
    logic             sr_perr, sr_lerr;
    logic             set_perr, set_lerr, clr_sr;
    logic             seg_locked;

    assign seg_locked = (seg == SEG_FACT && fact_locked) ||
                        (seg == SEG_USER && user_locked);

    always_comb begin
        state_nxt = state;
        prog_en   = 1'b0;
        set_perr  = 1'b0;
        set_lerr  = 1'b0;
        clr_sr    = 1'b0;
        cnt_load  = 1'b0;
        unique case (state)
            ST_ARRAY, ST_IDENT, ST_STATUS: begin
                if (wr_en) begin
                    case (cmd)
                        CMD_READ_ARRAY: state_nxt = ST_ARRAY;
                        CMD_READ_ID:    state_nxt = ST_IDENT;
                        CMD_PROG_SETUP: state_nxt = ST_PSETUP;
                        CMD_CLR_STATUS: clr_sr    = 1'b1;
                        default:        state_nxt = state;
                    endcase
                end
            end
            ST_PSETUP: begin
                if (wr_en) begin
                    state_nxt = ST_BUSY;
                    cnt_load  = 1'b1;
                    if (!hit) begin
                        set_perr = 1'b1;
                    end else if (seg_locked) begin
                        set_perr = 1'b1;
                        set_lerr = 1'b1;
                    end else begin
                        prog_en = 1'b1;
                    end
                end
            end
            ST_BUSY: begin
                if (cnt == '0)
                    state_nxt = ST_STATUS;
            end
            default: state_nxt = ST_ARRAY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_ARRAY;
            cnt     <= '0;
            sr_perr <= 1'b0;
            sr_lerr <= 1'b0;
        end else begin
            state <= state_nxt;
            if (cnt_load)
                cnt <= CNT_LOAD;
            else if (state == ST_BUSY && cnt != '0)
                cnt <= cnt - 1'b1;
            if (clr_sr) begin
                sr_perr <= 1'b0;
                sr_lerr <= 1'b0;
            end else begin
                if (set_perr) sr_perr <= 1'b1;
                if (set_lerr) sr_lerr <= 1'b1;
            end
        end
    end

    assign status = {state != ST_BUSY, 2'b00, sr_perr, 2'b00, sr_lerr, 1'b0};

    assert_busy_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && $past(state) != ST_BUSY) |-> $past(state == ST_PSETUP && wr_en));

    assert_busy_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_BUSY && state != ST_BUSY) |-> state == ST_STATUS);

    assert_err_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr_perr) |-> $past(state == ST_PSETUP && wr_en));

    assert_lock_err_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sr_lerr |-> sr_perr);

    assert_clear_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && cmd == CMD_CLR_STATUS &&
              (state == ST_ARRAY || state == ST_IDENT || state == ST_STATUS))
        |-> (!sr_perr && !sr_lerr));

endmodule

// File: rtl/otp_prot_ctrl.sv
module otp_prot_ctrl
    import otp_prot_pkg::*;
#(
    parameter int                ADDR_W      = 9,
    parameter logic [ADDR_W-1:0] PR_BASE     = 'h80,
    parameter int                BUSY_CYCLES = 4,
    parameter logic [63:0]       FACTORY_ID  = 64'h0123_4567_89AB_CDEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata
);

    logic              hit, lane, fact_locked, user_locked, prog_en;
    logic [SLOT_W-1:0] slot;
    otp_seg_e          seg;
    otp_state_e        state;
    logic [7:0]        status;
    logic [15:0]       words [PR_WORDS];
    logic [15:0]       id_word;

    otp_addr_dec #(.ADDR_W(ADDR_W), .PR_BASE(PR_BASE)) dec_i (
        .byte_mode (byte_mode),
        .addr      (addr),
        .hit       (hit),
        .lane      (lane),
        .slot      (slot),
        .seg       (seg)
    );

    otp_store #(.FACTORY_ID(FACTORY_ID)) store_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .prog_en     (prog_en),
        .slot        (slot),
        .byte_mode   (byte_mode),
        .lane        (lane),
        .wdata       (wdata),
        .words       (words),
        .fact_locked (fact_locked),
        .user_locked (user_locked)
    );

    otp_cmd_fsm #(.BUSY_CYCLES(BUSY_CYCLES)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .cmd         (wdata[7:0]),
        .hit         (hit),
        .seg         (seg),
        .fact_locked (fact_locked),
        .user_locked (user_locked),
        .state       (state),
        .status      (status),
        .prog_en     (prog_en)
    );

    always_comb begin
        id_word = '0;
        for (int i = 0; i < PR_WORDS; i++)
            if (hit && int'(slot) == i)
                id_word = words[i];
    end

    always_comb begin
        unique case (state)
            ST_ARRAY: rdata = 16'hFFFF;
            ST_IDENT: begin
                if (!byte_mode)
                    rdata = id_word;
                else
                    rdata = {8'h00, lane ? id_word[15:8] : id_word[7:0]};
            end
            default:  rdata = {8'h00, status};
        endcase
    end

endmodule

// File: tb/otp_prot_ctrl_tb.sv
module otp_prot_ctrl_tb_top;

    localparam int BUSY_CYCLES = 4;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_POLL = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic        bm;
        logic [8:0]  a;
        logic [15:0] d;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 44;
    localparam vec_t VECS [NVEC] = '{
        '{OP_WR,   1'b0, 9'h000, 16'h0090, 4'd2},  // R2 enter ident
        '{OP_RD,   1'b0, 9'h081, 16'hCDEF, 4'd2},
        '{OP_RD,   1'b0, 9'h084, 16'h0123, 4'd2},
        '{OP_RD,   1'b0, 9'h085, 16'hFFFF, 4'd2},
        '{OP_RD,   1'b0, 9'h080, 16'hFFFE, 4'd2},
        '{OP_RD,   1'b0, 9'h0A0, 16'h0000, 4'd2},
        '{OP_WR,   1'b0, 9'h000, 16'h00FF, 4'd3},  // R3
        '{OP_RD,   1'b0, 9'h081, 16'hFFFF, 4'd3},
        '{OP_WR,   1'b0, 9'h000, 16'h00C0, 4'd4},  // R4 program
        '{OP_WR,   1'b0, 9'h086, 16'hA5F0, 4'd4},
        '{OP_POLL, 1'b0, 9'h000, 16'h0080, 4'd4},
        '{OP_WR,   1'b0, 9'h000, 16'h0090, 4'd4},
        '{OP_RD,   1'b0, 9'h086, 16'hA5F0, 4'd4},
        '{OP_WR,   1'b0, 9'h000, 16'h00C0, 4'd4},  // R4 ones do not restore
        '{OP_WR,   1'b0, 9'h086, 16'hFFFF, 4'd4},
        '{OP_POLL, 1'b0, 9'h000, 16'h0080, 4'd4},
        '{OP_WR,   1'b0, 9'h000, 16'h0090, 4'd4},
        '{OP_RD,   1'b0, 9'h086, 16'hA5F0, 4'd4},
        '{OP_WR,   1'b0, 9'h000, 16'h00C0, 4'd4},  // R4 AND
        '{OP_WR,   1'b0, 9'h086, 16'h0F0F, 4'd4},
        '{OP_POLL, 1'b0, 9'h000, 16'h0080, 4'd4},
        '{OP_WR,   1'b0, 9'h000, 16'h0090, 4'd4},
        '{OP_RD,   1'b0, 9'h086, 16'h0500, 4'd4},
        '{OP_WR,   1'b1, 9'h000, 16'h00C0, 4'd5},  // R5 byte lane 1 of 0x87
        '{OP_WR,   1'b1, 9'h10F, 16'hAA3C, 4'd5},
        '{OP_POLL, 1'b1, 9'h000, 16'h0080, 4'd5},
        '{OP_WR,   1'b1, 9'h000, 16'h0090, 4'd5},
        '{OP_RD,   1'b1, 9'h10F, 16'h003C, 4'd5},
        '{OP_RD,   1'b1, 9'h10E, 16'h00FF, 4'd5},
        '{OP_RD,   1'b0, 9'h087, 16'h3CFF, 4'd5},
        '{OP_WR,   1'b0, 9'h000, 16'h00C0, 4'd6},  // R6 out of range
        '{OP_WR,   1'b0, 9'h090, 16'h0000, 4'd6},
        '{OP_POLL, 1'b0, 9'h000, 16'h0090, 4'd6},
        '{OP_WR,   1'b0, 9'h000, 16'h0050, 4'd10}, // R10 clear, stay in status
        '{OP_RD,   1'b0, 9'h081, 16'h0080, 4'd10},
        '{OP_WR,   1'b0, 9'h000, 16'h00C0, 4'd7},  // R7 fixed half
        '{OP_WR,   1'b0, 9'h082, 16'h0000, 4'd7},
        '{OP_POLL, 1'b0, 9'h000, 16'h0092, 4'd7},
        '{OP_WR,   1'b0, 9'h000, 16'h0050, 4'd7},
        '{OP_WR,   1'b0, 9'h000, 16'h0090, 4'd7},
        '{OP_RD,   1'b0, 9'h082, 16'h89AB, 4'd7},
        '{OP_WR,   1'b0, 9'h000, 16'h00C0, 4'd8},  // R8 lock user half
        '{OP_WR,   1'b0, 9'h080, 16'hFFFD, 4'd8},
        '{OP_POLL, 1'b0, 9'h000, 16'h0080, 4'd8}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [8:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;

    int n_checks = 0;
    int n_fail = 0;
    vec_t v;

    always #2 clk = ~clk;

    otp_prot_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_mode (byte_mode),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata)
    );

    task automatic check(input int req, input logic [15:0] got, input logic [15:0] exp, input string what);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic bus_write(input logic bm, input logic [8:0] a, input logic [15:0] d);
        @(negedge clk);
        byte_mode = bm; addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input int req, input logic bm, input logic [8:0] a, input logic [15:0] exp);
        byte_mode = bm; addr = a;
        #1;
        check(req, rdata, exp, "read");
    endtask

    task automatic poll_ready(input int req, input logic [15:0] exp);
        for (int k = 0; k < 64 && rdata[7] !== 1'b1; k++)
            @(negedge clk);
        #1;
        check(req, rdata, exp, "status after busy");
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int busy_n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state: array read and status
        bus_read(1, 1'b0, 9'h081, 16'hFFFF);
        bus_write(1'b0, 9'h000, 16'h00C0);
        bus_read(1, 1'b0, 9'h000, 16'h0080);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bus_read(1, 1'b0, 9'h085, 16'hFFFF);

        for (int i = 0; i < NVEC; i++) begin
            v = VECS[i];
            case (v.op)
                OP_WR:   bus_write(v.bm, v.a, v.d);
                OP_RD:   bus_read(int'(v.req), v.bm, v.a, v.d);
                default: poll_ready(int'(v.req), v.d);
            endcase
        end

        // R8 user half now locked: program rejected, word unchanged
        bus_write(1'b0, 9'h000, 16'h00C0);
        bus_write(1'b0, 9'h085, 16'h0000);
        poll_ready(8, 16'h0092);
        bus_write(1'b0, 9'h000, 16'h0050);
        bus_write(1'b0, 9'h000, 16'h0090);
        bus_read(8, 1'b0, 9'h085, 16'hFFFF);
        bus_read(8, 1'b0, 9'h080, 16'hFFFC);

        // R9 busy window length
        bus_write(1'b0, 9'h000, 16'h00C0);
        bus_write(1'b0, 9'h090, 16'h0000);
        busy_n = 0;
        #1;
        while (rdata[7] === 1'b0 && busy_n < 50) begin
            busy_n++;
            @(negedge clk);
            #1;
        end
        check(9, 16'(busy_n), 16'(BUSY_CYCLES), "busy cycle count");
        check(9, rdata, 16'h0090, "status after window");

        // R9 command written during busy is dropped
        bus_write(1'b0, 9'h000, 16'h0050);
        bus_write(1'b0, 9'h000, 16'h00C0);
        bus_write(1'b0, 9'h090, 16'h0000);
        bus_write(1'b0, 9'h081, 16'h0090);
        poll_ready(9, 16'h0090);
        bus_read(9, 1'b0, 9'h081, 16'h0090);

        // R10 clear status from ident mode keeps ident mode
        bus_write(1'b0, 9'h000, 16'h0090);
        bus_write(1'b0, 9'h000, 16'h0050);
        bus_read(10, 1'b0, 9'h081, 16'hCDEF);

        finish_run();
    end

endmodule